// File: doc/BRIEF.md
# Double-Buffered Dual-Compare PWM Channel

This block makes a pulse-width-modulated output from a 16-bit time-base value that is supplied from outside and that normally counts freely. Two compare values shape each pulse. The leading value starts the pulse. The trailing value ends it. Software writes the trailing value into a buffer register. The comparator never reads that buffer. It reads a hidden working copy, and the buffer is copied into the working copy only when the leading value matches. A new pulse width therefore starts cleanly at the beginning of the next period and never cuts the current pulse short.

A 3-bit mode field limits the comparison to a number of low bits, which shortens the period to 2^width time-base counts. A polarity bit swaps the levels the output takes on each match. If both values match at the same moment, the output goes low.

A status flag records every leading match. Software clears the flag by writing a one to it. Software reaches all of this through a plain register port. The port accepts a write on every cycle and has no back-pressure, and reads are combinational. No check stops software from loading leading and trailing values that make no sense together.

Top module: `pwm_dual_cmp`

## Requirements
- R1: After reset the output is low, the flag is clear, and the leading, trailing-buffer and control registers all read zero. The working trailing copy is also zero.
- R2: The register addresses are:
  - 0: leading value.
  - 1: trailing buffer.
  - 2: control. Bit 0 is the polarity and bits 3:1 are the mode.
  - 3: status. Bit 0 is the flag.

  A write takes effect at the clock edge. `rd_data` shows the addressed register in the same cycle, and unused bits read zero.
- R3: With polarity 0, a leading match sets the output high and a trailing match sets it low. The output changes at the clock edge that samples the matching time-base value.
- R4: With polarity 1, a leading match sets the output low and a trailing match sets it high.
- R5: The working trailing copy takes the buffer value only at a leading match. The value it takes is the one the buffer held before that edge. Writing the buffer at any other time leaves the current trailing edge unchanged.
- R6: When the leading and trailing matches happen in the same cycle, the output goes low, whatever the polarity.
- R7: Every leading match sets the flag. Writing a one to status bit 0 clears it, and writing a zero there has no effect. If a clear and a set happen in the same cycle, the set wins.
- R8: Mode values 0 to 6 compare the low 16, 15, 14, 13, 12, 11 and 10 bits, and mode 7 compares the low 8 bits. The masked upper bits are ignored in both comparisons.
- R9: A match counts only in a cycle in which the time-base value differs from the value it had one cycle earlier. A time base that holds steady on a compare value does not match again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_in | input | 16 | External time-base value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| pwm_out | output | 1 | PWM output |
| flag | output | 1 | Leading-match status flag |

## Verification
The bench builds the block with its default parameters: a 16-bit time base and the 3-bit mode field. Most random runs use modes 5 to 7, with widths of 11, 10 and 8 bits. Those short periods let the bench reach many leading-edge transfers, trailing-edge updates and wrap-arounds within the cycle budget. Equal-value contention, a time base that holds still, and a clear that collides with a set are all reachable that way.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_LEAD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_TRAIL = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd3;

  typedef struct packed {
    logic [2:0] mode;
    logic       pol;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dual_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TB_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TB_W-1:0]   rd_data,
  input  logic              flag,
  output logic [TB_W-1:0]   lead_val,
  output logic [TB_W-1:0]   trail_buf,
  output ctrl_t             ctrl,
  output logic              clr_flag
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_val  <= '0;
      trail_buf <= '0;
      ctrl      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_LEAD:  lead_val  <= wr_data;
        ADR_TRAIL: trail_buf <= wr_data;
        ADR_CTRL:  ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:   ;
      endcase
    end
  end

  assign clr_flag = wr_en && (wr_addr == ADR_STAT) && wr_data[0];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_LEAD:  rd_data = lead_val;
      ADR_TRAIL: rd_data = trail_buf;
      ADR_CTRL:  rd_data[CTRL_W-1:0] = ctrl;
      default:   rd_data[0] = flag;
    endcase
  end
endmodule

// File: rtl/pwm_match.sv
module pwm_match #(
  parameter int TB_W = 16,
  parameter int MIN_W = 8
) (
  input  logic [TB_W-1:0] tb_in,
  input  logic            tb_chg,
  input  logic [TB_W-1:0] cmp_val,
  input  logic [2:0]      mode,
  output logic            hit
);
  logic [TB_W-1:0] mask;
  int unsigned     width;

  always_comb begin
    width = (mode == 3'd7) ? MIN_W : TB_W - int'(mode);
    mask  = '0;
    for (int i = 0; i < TB_W; i++) begin
      if (i < width) mask[i] = 1'b1;
    end
  end

  assign hit = tb_chg && (((tb_in ^ cmp_val) & mask) == '0);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_lead,
  input  logic            hit_trail,
  input  logic            pol,
  input  logic [TB_W-1:0] trail_buf,
  input  logic            clr_flag,
  output logic [TB_W-1:0] trail_work,
  output logic            pwm_out,
  output logic            flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trail_work <= '0;
      pwm_out    <= 1'b0;
      flag       <= 1'b0;
    end else begin
      if (hit_lead) trail_work <= trail_buf;
      if (hit_lead && hit_trail) pwm_out <= 1'b0;
      else if (hit_lead)         pwm_out <= ~pol;
      else if (hit_trail)        pwm_out <= pol;
      if (hit_lead)      flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lead |=> flag); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !hit_lead) |=> !flag); // R7
  AST_CONTENTION_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lead && hit_trail) |=> !pwm_out); // R6
  AST_LEAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lead && !hit_trail) |=> (pwm_out == !$past(pol))); // R4
  AST_TRAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lead |=> (trail_work == $past(trail_buf))); // R5
  AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_lead |=> $stable(trail_work)); // R5
endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
  import pwm_dual_pkg::*;
#(
  parameter int TB_W = 16,
  parameter int MIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TB_W-1:0]   tb_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TB_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TB_W-1:0]   rd_data,
  output logic              pwm_out,
  output logic              flag
);
  localparam int N_CMP = 2;

  logic [TB_W-1:0] lead_val, trail_buf, trail_work, tb_prev;
  logic [TB_W-1:0] cmp_val [N_CMP];
  logic [N_CMP-1:0] hit;
  ctrl_t ctrl;
  logic  clr_flag, tb_chg;

  always_ff @(posedge clk) tb_prev <= tb_in;
  assign tb_chg = (tb_in != tb_prev);

  pwm_regs #(.TB_W(TB_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag(flag), .lead_val(lead_val),
    .trail_buf(trail_buf), .ctrl(ctrl), .clr_flag(clr_flag)
  );

  assign cmp_val[0] = lead_val;
  assign cmp_val[1] = trail_work;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    pwm_match #(.TB_W(TB_W), .MIN_W(MIN_W)) match_i (
      .tb_in(tb_in), .tb_chg(tb_chg), .cmp_val(cmp_val[g]),
      .mode(ctrl.mode), .hit(hit[g])
    );
  end

  pwm_out_stage #(.TB_W(TB_W)) out_i (
    .clk(clk), .rst_n(rst_n), .hit_lead(hit[0]), .hit_trail(hit[1]),
    .pol(ctrl.pol), .trail_buf(trail_buf), .clr_flag(clr_flag),
    .trail_work(trail_work), .pwm_out(pwm_out), .flag(flag)
  );

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(tb_in) |=> $stable(pwm_out)); // R9
  AST_HOLD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(tb_in) && !flag) |=> !flag); // R9
endmodule

// File: tb/pwm_dual_cmp_tb.sv
module pwm_dual_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tb_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_out, flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state
  logic [15:0] m_a, m_b1, m_b2, m_prev;
  logic [3:0]  m_ctrl;
  logic        m_out, m_flag;

  always #2.5 clk = ~clk;

  pwm_dual_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .tb_in(tb_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .flag(flag)
  );

  function automatic logic [15:0] mask_of(input logic [2:0] mode);
    int w;
    w = (mode == 3'd7) ? 8 : 16 - int'(mode);
    return 16'((32'd1 << w) - 1);
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_a;
      2'd1: return m_b1;
      2'd2: return {12'd0, m_ctrl};
      default: return {15'd0, m_flag};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // One clock: inputs driven at negedge, model advanced, outputs sampled after posedge.
  task automatic step(input logic [15:0] t, input bit we, input logic [1:0] wa, input logic [15:0] wd);
    logic [15:0] mk;
    bit ma, mb, chg;
    tb_in = t; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_addr = 2'($urandom_range(0, 3));
    mk  = mask_of(m_ctrl[3:1]);
    chg = (t != m_prev);
    ma  = chg && (((t ^ m_a) & mk) == 0);
    mb  = chg && (((t ^ m_b2) & mk) == 0);
    if (ma && mb) m_out = 1'b0;          // R6
    else if (ma) m_out = ~m_ctrl[0];     // R3 R4
    else if (mb) m_out = m_ctrl[0];
    if (ma) m_b2 = m_b1;                 // R5
    if (ma) m_flag = 1'b1;               // R7 set wins
    else if (we && wa == 2'd3 && wd[0]) m_flag = 1'b0;
    if (we) begin
      case (wa)
        2'd0: m_a = wd;
        2'd1: m_b1 = wd;
        2'd2: m_ctrl = wd[3:0];
        default: ;
      endcase
    end
    m_prev = t;
    @(posedge clk); #1;
    chk(pwm_out == m_out, "R3 R4 R5 R6 R8 R9 pwm_out", {15'd0, pwm_out}, {15'd0, m_out});
    chk(flag == m_flag, "R7 R9 flag", {15'd0, flag}, {15'd0, m_flag});
    chk(rd_data == exp_read(rd_addr), "R2 rd_data", rd_data, exp_read(rd_addr));
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(m_prev, 1'b1, a, d);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] t;
    void'($urandom(32'd1234));
    m_a = 0; m_b1 = 0; m_b2 = 0; m_ctrl = 0; m_out = 0; m_flag = 0; m_prev = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk(rd_data == 16'd0, "R1 reset read", rd_data, 16'd0);
    end
    chk(!pwm_out && !flag, "R1 reset outputs", {14'd0, pwm_out, flag}, 16'd0);
    @(negedge clk);

    // R2: readback of every register
    wr(2'd0, 16'h0010); wr(2'd1, 16'h0020); wr(2'd2, 16'h0000);
    // R3 R5: first period loads working copy at the leading match
    for (int i = 1; i < 16'h0060; i++) begin
      if (i == 16'h0030) begin
        step(16'(i), 1'b1, 2'd1, 16'h0040); // R5: buffer written mid-period
      end else step(16'(i), 1'b0, 2'd0, 16'h0);
    end
    for (int i = 0; i < 16'h0050; i++) step(16'(i), 1'b0, 2'd0, 16'h0);
    // R7: write zero leaves flag, write one clears
    wr(2'd3, 16'h0000); wr(2'd3, 16'h0001);
    // R7: clear collides with a leading match; set wins
    step(16'h0050, 1'b0, 2'd0, 16'h0);
    step(16'h0010, 1'b1, 2'd3, 16'h0001);
    // R9: time base held on a compare value; no re-match after clear
    wr(2'd3, 16'h0001);
    repeat (5) step(16'h0010, 1'b0, 2'd0, 16'h0);
    // R6: equal values with polarity 1
    wr(2'd1, 16'h0010); wr(2'd2, 16'h0001);
    step(16'h0011, 1'b0, 2'd0, 16'h0);
    step(16'h0010, 1'b0, 2'd0, 16'h0);
    step(16'h0011, 1'b0, 2'd0, 16'h0);
    step(16'h0010, 1'b0, 2'd0, 16'h0);
    // R8: mode 7 ignores upper bits
    wr(2'd0, 16'hAB05); wr(2'd1, 16'h7790); wr(2'd2, 16'h000E);
    for (int i = 0; i < 1024; i++) step(16'(i), 1'b0, 2'd0, 16'h0);

    // Random phase: short periods, random writes, occasional holds
    t = 16'($urandom);
    for (int i = 0; i < 30000; i++) begin
      bit we;
      logic [1:0] wa;
      logic [15:0] wd;
      we = ($urandom_range(0, 99) < 4);
      wa = 2'($urandom_range(0, 3));
      wd = 16'($urandom);
      if (we && wa == 2'd2) wd[3:1] = 3'($urandom_range(5, 7));
      if ($urandom_range(0, 9) != 0) t = t + 16'd1;
      step(t, we, wa, wd);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule